// File: doc/BRIEF.md
# Linear-Prediction Speech Synthesizer with Time Stretching

The block rebuilds speech samples from one frame of linear-prediction parameters at a time. A frame supplies a voicing decision, a pitch period, a gain and a set of all-pole filter coefficients. The block forms an excitation from it: a pulse train for voiced frames, pseudo-random noise for unvoiced ones. It scales the excitation by the gain and feeds it through a direct-form all-pole filter. The filter produces one output sample per clock while a frame is running.

Each frame also carries an output length in samples, set independently of the nominal analysis frame. A longer frame simply receives more pitch pulses at the same spacing. Playback can therefore be slowed or sped up while the perceived pitch stays the same. The pulse phase counter, the noise generator and the filter history all carry over from one frame to the next, so frame joins introduce no discontinuity.

Parameters enter through a valid/ready handshake that is accepted only between frames. Samples leave as a stream with a valid flag and an end-of-frame marker.

Top module: `lpc_stretch_synth`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `prm_ready` is 1, `smp_valid` is 0 and `smp_data` is 0.
- R2: A parameter set is taken only on a clock edge where `prm_valid` and `prm_ready` are both 1. `prm_ready` is 0 from the edge after acceptance until the final sample of that frame is presented. Inputs offered during a running frame have no effect on its samples.
- R3: An accepted frame produces exactly its effective length of samples on consecutive cycles. `smp_last` is 1 only with the final sample.
- R4: The effective length is `prm_len` clamped to the range NOM_LEN/2 to 4*NOM_LEN inclusive.
- R5: In a voiced frame (`prm_voiced`=1), the scaled excitation is +gain on a sample where the pulse phase is 0, and 0 otherwise. After every sample the phase becomes 0 if phase+1 >= pitch, else phase+1.
- R6: The pulse phase, and the noise register, advance on every emitted sample of any frame. They keep their values across frame boundaries and idle cycles. Both start from reset with phase 0.
- R7: In an unvoiced frame, the scaled excitation is +gain when bit 0 of a 16-bit noise register is 1, and -gain otherwise. The register starts at 0xACE1. It advances each sample by a right shift, XOR-ing 0xB400 into the result when the bit shifted out was 1.
- R8: Each sample is y = floor((e*4096 + sum over k of a_k * y[n-k]) / 4096). Here e is the scaled excitation, and a_k is the signed Q12 field `prm_coef[(k-1)*16 +: 16]` for k = 1..ORDER.
- R9: y is saturated to the range -32768..32767 before it is output and before it is stored as history.
- R10: The filter history persists across frame boundaries and idle gaps, and is cleared only by reset.
- R11: The same pitch period gives the same pulse spacing whatever output frame length is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prm_valid | input | 1 | Parameter set offered |
| prm_ready | output | 1 | Block can accept a parameter set (idle) |
| prm_voiced | input | 1 | 1 = pulse excitation, 0 = noise excitation |
| prm_pitch | input | PW (8) | Pitch period in samples |
| prm_gain | input | SW-1 (15) | Unsigned excitation gain |
| prm_coef | input | ORDER*CW (160) | Packed signed Q12 coefficients, a_1 in the low field |
| prm_len | input | LW (10) | Requested output frame length in samples |
| smp_valid | output | 1 | Output sample present |
| smp_last | output | 1 | Final sample of the frame |
| smp_data | output | SW (16) | Signed synthesized sample |

## Verification
The hardest situation to reach is a frame join where the pitch pulse falls in mid-period and the filter still holds a decaying or saturated history. Only then do phase carry and history carry show up at the output. The stimulus sets this up in two steps. First it sends a voiced frame whose clamped length is not a multiple of the pitch. It follows this with frames of other lengths and zero gain, so the ringing of the previous frame is the only signal left. A high-gain frame with a coefficient above unity drives the filter into saturation before a flushing frame follows. Junk parameters are also held on the inputs during a running frame, to show that they are ignored.

// File: rtl/lpc_pkg.sv
// Shared constants and helpers for the linear-prediction synthesizer.
// Assumes a 16-bit Galois noise register and Q12 coefficient scaling.
package lpc_pkg;
    localparam int FRAC = 12;
    localparam logic [15:0] NOISE_SEED = 16'hACE1;
    localparam logic [15:0] NOISE_TAPS = 16'hB400;

    // Advance the Galois noise register by one step.
    function automatic logic [15:0] noise_step(input logic [15:0] s);
        logic [15:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ NOISE_TAPS;
        return n;
    endfunction
endpackage

// File: rtl/lpc_frame_ctl.sv
// Frame controller: accepts a parameter set while idle, clamps the
// requested length to the stretch range, holds the parameters and counts
// down the samples of the frame. Assumes 4*NOM_LEN < 2**LW.
module lpc_frame_ctl #(
    parameter int ORDER   = 10,
    parameter int CW      = 16,
    parameter int GW      = 15,
    parameter int PW      = 8,
    parameter int LW      = 10,
    parameter int NOM_LEN = 160
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic                in_voiced,
    input  logic [PW-1:0]       in_pitch,
    input  logic [GW-1:0]       in_gain,
    input  logic [ORDER*CW-1:0] in_coef,
    input  logic [LW-1:0]       in_len,
    output logic                step,
    output logic                last_step,
    output logic                voiced,
    output logic [PW-1:0]       pitch,
    output logic [GW-1:0]       gain,
    output logic [ORDER*CW-1:0] coef
);
    localparam logic [LW-1:0] MIN_L = LW'(NOM_LEN / 2);
    localparam logic [LW-1:0] MAX_L = LW'(NOM_LEN * 4);

    logic [LW-1:0] remain;
    logic [LW-1:0] eff_len;

    // Clamp the requested length into the supported stretch range.
    always_comb begin
        if (in_len < MIN_L)      eff_len = MIN_L;
        else if (in_len > MAX_L) eff_len = MAX_L;
        else                     eff_len = in_len;
    end

    assign in_ready  = (remain == '0);
    assign step      = (remain != '0);
    assign last_step = (remain == LW'(1));

    // Load a new frame when idle, else count down emitted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            voiced <= 1'b0;
            pitch  <= '0;
            gain   <= '0;
            coef   <= '0;
        end else if (in_valid && in_ready) begin
            remain <= eff_len;
            voiced <= in_voiced;
            pitch  <= in_pitch;
            gain   <= in_gain;
            coef   <= in_coef;
        end else if (step) begin
            remain <= remain - LW'(1);
        end
    end
endmodule

// File: rtl/lpc_excite.sv
// Excitation source: pitch pulse train or +/- noise, scaled by the gain.
// The phase counter and noise register advance on every emitted sample
// and are never reloaded at a frame boundary.
module lpc_excite #(
    parameter int SW = 16,
    parameter int PW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic                 voiced,
    input  logic [PW-1:0]        pitch,
    input  logic [SW-2:0]        gain,
    output logic signed [SW-1:0] exc
);
    import lpc_pkg::*;

    logic [PW-1:0] phase;
    logic [15:0]   noise;
    logic [PW:0]   ph_inc;
    logic signed [SW-1:0] g_s;

    assign ph_inc = {1'b0, phase} + (PW+1)'(1);
    assign g_s    = $signed({1'b0, gain});

    // Select the excitation value for the current sample.
    always_comb begin
        if (voiced) exc = (phase == '0) ? g_s : '0;
        else        exc = noise[0] ? g_s : -g_s;
    end

    // Advance pulse phase and noise register once per emitted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            noise <= NOISE_SEED;
        end else if (step) begin
            phase <= (ph_inc >= {1'b0, pitch}) ? '0 : ph_inc[PW-1:0];
            noise <= noise_step(noise);
        end
    end
endmodule

// File: rtl/lpc_allpole.sv
// Direct-form all-pole synthesis filter with saturating output.
// hist[0] holds y[n-1]; coefficient field k holds a_(k+1) in Q FRAC.
module lpc_allpole #(
    parameter int ORDER = 10,
    parameter int CW    = 16,
    parameter int SW    = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step,
    input  logic signed [SW-1:0] exc,
    input  logic [ORDER*CW-1:0]  coef,
    output logic signed [SW-1:0] y
);
    import lpc_pkg::*;

    localparam int AW = SW + CW + $clog2(ORDER + 1) + 2;
    localparam logic signed [AW-1:0] YMAX = AW'(2 ** (SW - 1) - 1);
    localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

    logic signed [SW-1:0]    hist [ORDER];
    logic signed [CW+SW-1:0] prod [ORDER];
    logic signed [AW-1:0]    acc;
    logic signed [AW-1:0]    sh;

    // One product and one history stage per filter tap.
    for (genvar g = 0; g < ORDER; g++) begin : g_tap
        assign prod[g] = $signed(coef[g*CW +: CW]) * hist[g];

        // Shift the history line by one sample.
        always_ff @(posedge clk) begin
            if (!rst_n)    hist[g] <= '0;
            else if (step) hist[g] <= (g == 0) ? y : hist[(g == 0) ? 0 : g-1];
        end
    end

    // Sum excitation and feedback, rescale and saturate.
    always_comb begin
        acc = AW'(exc);
        acc = acc <<< FRAC;
        for (int k = 0; k < ORDER; k++) acc = acc + AW'(prod[k]);
        sh = acc >>> FRAC;
        if (sh > YMAX)      y = YMAX[SW-1:0];
        else if (sh < YMIN) y = YMIN[SW-1:0];
        else                y = sh[SW-1:0];
    end
endmodule

// File: rtl/lpc_stretch_synth.sv
// Top: linear-prediction synthesizer with programmable output frame
// length. One sample per clock while a frame runs; the output is registered.
module lpc_stretch_synth #(
    parameter int ORDER   = 10,
    parameter int CW      = 16,
    parameter int SW      = 16,
    parameter int PW      = 8,
    parameter int LW      = 10,
    parameter int NOM_LEN = 160
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                prm_valid,
    output logic                prm_ready,
    input  logic                prm_voiced,
    input  logic [PW-1:0]       prm_pitch,
    input  logic [SW-2:0]       prm_gain,
    input  logic [ORDER*CW-1:0] prm_coef,
    input  logic [LW-1:0]       prm_len,
    output logic                smp_valid,
    output logic                smp_last,
    output logic [SW-1:0]       smp_data
);
    logic                step, last_step, voiced;
    logic [PW-1:0]       pitch;
    logic [SW-2:0]       gain;
    logic [ORDER*CW-1:0] coef;
    logic signed [SW-1:0] exc, y;

    lpc_frame_ctl #(.ORDER(ORDER), .CW(CW), .GW(SW-1), .PW(PW), .LW(LW),
                    .NOM_LEN(NOM_LEN)) u_ctl (
        .clk(clk), .rst_n(rst_n), .in_valid(prm_valid), .in_ready(prm_ready),
        .in_voiced(prm_voiced), .in_pitch(prm_pitch), .in_gain(prm_gain),
        .in_coef(prm_coef), .in_len(prm_len), .step(step),
        .last_step(last_step), .voiced(voiced), .pitch(pitch),
        .gain(gain), .coef(coef)
    );

    lpc_excite #(.SW(SW), .PW(PW)) u_exc (
        .clk(clk), .rst_n(rst_n), .step(step), .voiced(voiced),
        .pitch(pitch), .gain(gain), .exc(exc)
    );

    lpc_allpole #(.ORDER(ORDER), .CW(CW), .SW(SW)) u_flt (
        .clk(clk), .rst_n(rst_n), .step(step), .exc(exc), .coef(coef), .y(y)
    );

    // Register the sample stream and its frame marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_valid <= 1'b0;
            smp_last  <= 1'b0;
            smp_data  <= '0;
        end else begin
            smp_valid <= step;
            smp_last  <= last_step;
            if (step) smp_data <= y;
        end
    end
endmodule

// File: rtl/lpc_stretch_synth_chk.sv
// Protocol checker for lpc_stretch_synth, attached through bind.
// Tracks the length of each output run with its own counter.
module lpc_stretch_synth_chk #(
    parameter int NOM_LEN = 160,
    parameter int SW      = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          prm_valid,
    input logic          prm_ready,
    input logic          smp_valid,
    input logic          smp_last,
    input logic [SW-1:0] smp_data
);
    localparam int RW = $clog2(4 * NOM_LEN + 2) + 1;
    logic [RW-1:0] run_len;

    // Count samples seen so far in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_len <= '0;
        else if (smp_valid)         run_len <= smp_last ? '0 : run_len + RW'(1);
    end

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!smp_valid && prm_ready && smp_data == '0));
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (prm_valid && prm_ready) |=> !prm_ready);
    a_r2_not_ready_mid_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_last) |-> !prm_ready);
    a_r3_ready_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_last) |-> prm_ready);
    a_r3_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !smp_last) |=> smp_valid);
    a_r4_max_len: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |-> (run_len < RW'(4 * NOM_LEN)));
    a_r4_min_len: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && smp_last) |-> (run_len + RW'(1) >= RW'(NOM_LEN / 2)));
endmodule

bind lpc_stretch_synth lpc_stretch_synth_chk #(.NOM_LEN(NOM_LEN), .SW(SW)) u_chk (
    .clk(clk), .rst_n(rst_n), .prm_valid(prm_valid), .prm_ready(prm_ready),
    .smp_valid(smp_valid), .smp_last(smp_last), .smp_data(smp_data)
);

// File: tb/lpc_stretch_synth_bench.sv
// Scoreboard bench: send_frame models the expected samples and queues
// them; a monitor pops and compares every sample the design emits.
module lpc_stretch_synth_bench;
    localparam int ORDER = 10;
    localparam int NOM   = 16;
    localparam int MINL  = NOM / 2;
    localparam int MAXL  = NOM * 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         prm_valid = 1'b0;
    logic         prm_ready;
    logic         prm_voiced = 1'b0;
    logic [7:0]   prm_pitch = '0;
    logic [14:0]  prm_gain = '0;
    logic [159:0] prm_coef = '0;
    logic [9:0]   prm_len = '0;
    logic         smp_valid, smp_last;
    logic [15:0]  smp_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int    q_d[$];
    bit    q_l[$];
    string q_r[$];

    int       cf [ORDER];
    int       m_phase = 0;
    bit [15:0] m_noise = 16'hACE1;
    longint   m_hist [ORDER];

    always #10 clk = ~clk;

    lpc_stretch_synth #(.NOM_LEN(NOM)) u_lpc_stretch_synth (
        .clk(clk), .rst_n(rst_n), .prm_valid(prm_valid), .prm_ready(prm_ready),
        .prm_voiced(prm_voiced), .prm_pitch(prm_pitch), .prm_gain(prm_gain),
        .prm_coef(prm_coef), .prm_len(prm_len), .smp_valid(smp_valid),
        .smp_last(smp_last), .smp_data(smp_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model a frame, queue its samples, then drive it through the handshake.
    task automatic send_frame(input bit v, input int pitch, input int gain,
                              input int len, input string req, input bit junk);
        int eff;
        longint e, acc, y;
        eff = (len < MINL) ? MINL : (len > MAXL) ? MAXL : len;
        for (int i = 0; i < eff; i++) begin
            if (v) e = (m_phase == 0) ? gain : 0;
            else   e = m_noise[0] ? gain : -gain;
            acc = e * 4096;
            for (int k = 0; k < ORDER; k++) acc += cf[k] * m_hist[k];
            y = acc >>> 12;
            if (y > 32767) y = 32767;
            if (y < -32768) y = -32768;
            for (int k = ORDER - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
            m_hist[0] = y;
            m_phase = (m_phase + 1 >= pitch) ? 0 : m_phase + 1;
            m_noise = m_noise[0] ? ((m_noise >> 1) ^ 16'hB400) : (m_noise >> 1);
            q_d.push_back(int'(y));
            q_l.push_back(i == eff - 1);
            q_r.push_back(req);
        end
        @(negedge clk);
        while (!prm_ready) @(negedge clk);
        prm_valid  = 1'b1;
        prm_voiced = v;
        prm_pitch  = 8'(pitch);
        prm_gain   = 15'(gain);
        prm_len    = 10'(len);
        for (int k = 0; k < ORDER; k++) prm_coef[k*16 +: 16] = 16'(cf[k]);
        @(negedge clk);
        if (junk) begin
            // R2: offer other parameters while the frame runs
            prm_voiced = ~v; prm_pitch = 8'd3; prm_gain = 15'd7777;
            prm_len = 10'd200; prm_coef = {160{1'b1}};
            for (int j = 0; j < 4; j++) begin
                check("R2 ready low mid-frame", prm_ready, 0);
                @(negedge clk);
            end
        end
        prm_valid = 1'b0;
    endtask

    // Monitor: compare each emitted sample against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && smp_valid && !done) begin
            if (q_d.size() == 0) begin
                check("R3 unexpected sample", 1, 0);
            end else begin
                string r;
                int d;
                bit l;
                d = q_d.pop_front(); l = q_l.pop_front(); r = q_r.pop_front();
                check(r, longint'($signed(smp_data)), d);
                check({r, " / R3 last flag"}, smp_last, l);
            end
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int k = 0; k < ORDER; k++) begin cf[k] = 0; m_hist[k] = 0; end
        repeat (3) @(negedge clk);
        check("R1 ready in reset", prm_ready, 1);
        check("R1 valid in reset", smp_valid, 0);
        check("R1 data in reset", smp_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", prm_ready, 1);
        check("R1 valid after reset", smp_valid, 0);

        // R5: plain pulse train, pitch 5, nominal length
        send_frame(1, 5, 1000, 16, "R5 voiced pulses", 0);
        // R6 R11: stretched frame, phase carried from 16 mod 5
        send_frame(1, 5, 1000, 40, "R6 R11 stretched pulses", 1);
        // R4: clamp both ends
        send_frame(1, 5, 1000, 3, "R4 clamp to min", 0);
        send_frame(1, 5, 1000, 200, "R4 clamp to max", 0);
        // R7: noise excitation
        send_frame(0, 5, 300, 16, "R7 noise", 0);
        // R8: resonant filter, then R10 ringing into a silent frame
        cf[0] = 3686; cf[1] = -1000; cf[4] = 500; cf[9] = -200;
        send_frame(1, 7, 2000, 19, "R8 filtered voice", 0);
        send_frame(1, 7, 0, 11, "R10 history carry", 0);
        // R9: unstable filter saturates both ways
        for (int k = 0; k < ORDER; k++) cf[k] = 0;
        cf[0] = 6144;
        send_frame(1, 50, 20000, 16, "R9 positive saturation", 0);
        cf[0] = -6144;
        send_frame(1, 50, 0, 16, "R9 negative saturation", 0);
        cf[0] = 0;
        send_frame(0, 9, 32767, 20, "R7 R9 full gain noise", 1);

        @(negedge clk);
        while (!prm_ready || q_d.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R3 scoreboard drained", q_d.size(), 0);
        check("R3 idle valid low", smp_valid, 0);
        done = 1'b1;
        report();
    end
endmodule